// File: doc/BRIEF.md
# System Instruction Control Unit

This block carries out the part of a core's SYSTEM-opcode instructions that touches control state. It covers the six CSR read-modify-write forms, the machine and supervisor trap returns, and the wait-for-interrupt instruction. The CSR storage sits outside the block. It presents the current value of the addressed register on `csr_old` in the issue cycle, and it accepts the write that comes back on `csr_we`, `csr_waddr` and `csr_wdata`. On a return, the block hands the core a new PC, a new privilege and the unwound status word. On a wait-for-interrupt, it raises a stall flag that stays high until an enabled interrupt becomes pending.

Every result is registered, so each output reflects the instruction issued in the previous cycle. The strobes `rd_valid`, `csr_we` and `ret_take` are each high for exactly one cycle per instruction. Access-permission checks and trap generation are left to the surrounding pipeline.

Top module: `sys_ctl_unit`

## Requirements
- R1: With `funct3` equal to 001, 010 or 011, the operand is `src_val`. The write data is then the operand itself (write), `csr_old | operand` (set) or `csr_old & ~operand` (clear), and `csr_waddr` is the issued `funct12`.
- R2: With `funct3` equal to 101, 110 or 111, the operand is `src_idx` zero-extended to XLEN. The same write, set and clear rules as in R1 then apply.
- R3: All six CSR forms raise `rd_valid` and return the unmodified `csr_old` on `rd_data`.
- R4: The set and clear forms suppress `csr_we` when `src_idx` is zero, in both the register and the immediate variants. The write forms always raise `csr_we`, including with a zero index.
- R5: With `funct3` = 000 and `funct12` = 0x302 (machine return), `ret_pc` = `mepc_in` and `ret_priv` = `mstatus_in[12:11]`. In `status_wdata`, bit 3 takes old bit 7, bit 7 becomes 1 and bits 12:11 become 0. All other bits are unchanged, apart from bit 17 as given in R7.
- R6: With `funct3` = 000 and `funct12` = 0x102 (supervisor return), `ret_pc` = `sepc_in` and `ret_priv` = {0, `mstatus_in[8]`}. In `status_wdata`, bit 1 takes old bit 5, bit 5 becomes 1 and bit 8 becomes 0. All other bits are unchanged, apart from bit 17 as given in R7.
- R7: On either return, status bit 17 is cleared when the new privilege is not machine (2'b11). It is kept when the new privilege is machine.
- R8: With `funct3` = 000 and `funct12` = 0x105, `wfi_wait` goes high in the cycle after issue. It stays high until `irq_enable & irq_pending` is non-zero, and falls in the cycle after that condition is first seen.
- R9: While `wfi_wait` is high, issued instructions are ignored and produce no strobe. Issue works again once the flag has fallen.
- R10: A `funct3` = 000 encoding whose `funct12[11:5]` is 0001001 (address-translation fence) completes with no strobe and no change to `wfi_wait`.
- R11: Results appear one cycle after issue. Each strobe lasts that one cycle only, and `csr_we` and `ret_take` are never high together.
- R12: After reset, `rd_valid`, `csr_we`, `ret_take` and `wfi_wait` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | A SYSTEM-opcode instruction is presented this cycle |
| funct3 | input | 3 | Minor opcode of the instruction |
| funct12 | input | 12 | CSR address or function field |
| src_idx | input | 5 | Source register index or 5-bit immediate |
| src_val | input | XLEN | Source register value |
| csr_old | input | XLEN | Current value of the addressed CSR |
| mstatus_in | input | XLEN | Current machine status word |
| mepc_in | input | XLEN | Machine exception PC |
| sepc_in | input | XLEN | Supervisor exception PC |
| irq_enable | input | XLEN | Interrupt enable mask |
| irq_pending | input | XLEN | Interrupt pending bits |
| rd_valid | output | 1 | Destination write strobe |
| rd_data | output | XLEN | Old CSR value for the destination |
| csr_we | output | 1 | CSR write strobe |
| csr_waddr | output | 12 | CSR write address |
| csr_wdata | output | XLEN | CSR write data |
| ret_take | output | 1 | Trap-return strobe: PC, privilege and status update |
| ret_pc | output | XLEN | PC to resume at |
| ret_priv | output | 2 | Privilege to resume in |
| status_wdata | output | XLEN | Unwound status word |
| wfi_wait | output | 1 | Stall flag while waiting for an interrupt |

## Verification
The properties assume that `issue_valid` is low during reset. They also assume that `csr_old` is the value of the register named by `funct12` in the issue cycle. The stimulus drives `issue_valid` for a single cycle per instruction and always changes inputs on the falling edge. Pending and enable masks are moved only at chosen points, so that the wake-up cycle of a wait is known. Return tests choose status words in which the bits being unwound have values that differ from their results, so that any missed copy or clear shows up.

// File: rtl/sys_ctl_pkg.sv
package sys_ctl_pkg;
    localparam int FN_W  = 12;
    localparam int IDX_W = 5;

    localparam logic [FN_W-1:0] FN_MRET      = 12'h302;
    localparam logic [FN_W-1:0] FN_SRET      = 12'h102;
    localparam logic [FN_W-1:0] FN_WFI       = 12'h105;
    localparam logic [6:0]      FN_FENCE_HI  = 7'b0001001;

    localparam logic [2:0] F3_PRIV = 3'b000;

    localparam logic [1:0] PRIV_M = 2'b11;

    // status word bit positions
    localparam int ST_SIE  = 1;
    localparam int ST_MIE  = 3;
    localparam int ST_SPIE = 5;
    localparam int ST_MPIE = 7;
    localparam int ST_SPP  = 8;
    localparam int ST_MPPL = 11;
    localparam int ST_MPPH = 12;
    localparam int ST_MPRV = 17;
endpackage

// File: rtl/sys_csr_rmw.sv
module sys_csr_rmw
    import sys_ctl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [2:0]       funct3,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  old_val,
    output logic             is_csr,
    output logic             wr_en,
    output logic [XLEN-1:0]  wdata
);
    logic [XLEN-1:0] operand;

    always_comb begin
        // bit 2 of funct3 selects the immediate variant
        operand = funct3[2] ? {{(XLEN-IDX_W){1'b0}}, src_idx} : src_val;
        is_csr  = (funct3[1:0] != 2'b00);
        unique case (funct3[1:0])
            2'b01: begin
                wdata = operand;
                wr_en = 1'b1;
            end
            2'b10: begin
                wdata = old_val | operand;
                wr_en = (src_idx != '0);
            end
            2'b11: begin
                wdata = old_val & ~operand;
                wr_en = (src_idx != '0);
            end
            default: begin
                wdata = old_val;
                wr_en = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sys_trap_ret.sv
module sys_trap_ret
    import sys_ctl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic            do_mret,
    input  logic            do_sret,
    input  logic [XLEN-1:0] mstatus,
    input  logic [XLEN-1:0] mepc,
    input  logic [XLEN-1:0] sepc,
    output logic            take,
    output logic [XLEN-1:0] tgt_pc,
    output logic [1:0]      tgt_priv,
    output logic [XLEN-1:0] new_status
);
    always_comb begin
        new_status = mstatus;
        if (do_sret) begin
            tgt_pc               = sepc;
            tgt_priv             = {1'b0, mstatus[ST_SPP]};
            new_status[ST_SIE]   = mstatus[ST_SPIE];
            new_status[ST_SPIE]  = 1'b1;
            new_status[ST_SPP]   = 1'b0;
        end else begin
            tgt_pc                      = mepc;
            tgt_priv                    = mstatus[ST_MPPH:ST_MPPL];
            new_status[ST_MIE]          = mstatus[ST_MPIE];
            new_status[ST_MPIE]         = 1'b1;
            new_status[ST_MPPH:ST_MPPL] = 2'b00;
        end
        if (tgt_priv != PRIV_M) begin
            new_status[ST_MPRV] = 1'b0;
        end
        take = do_mret | do_sret;
    end
endmodule

// File: rtl/sys_ctl_unit.sv
module sys_ctl_unit
    import sys_ctl_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue_valid,
    input  logic [2:0]       funct3,
    input  logic [FN_W-1:0]  funct12,
    input  logic [IDX_W-1:0] src_idx,
    input  logic [XLEN-1:0]  src_val,
    input  logic [XLEN-1:0]  csr_old,
    input  logic [XLEN-1:0]  mstatus_in,
    input  logic [XLEN-1:0]  mepc_in,
    input  logic [XLEN-1:0]  sepc_in,
    input  logic [XLEN-1:0]  irq_enable,
    input  logic [XLEN-1:0]  irq_pending,
    output logic             rd_valid,
    output logic [XLEN-1:0]  rd_data,
    output logic             csr_we,
    output logic [FN_W-1:0]  csr_waddr,
    output logic [XLEN-1:0]  csr_wdata,
    output logic             ret_take,
    output logic [XLEN-1:0]  ret_pc,
    output logic [1:0]       ret_priv,
    output logic [XLEN-1:0]  status_wdata,
    output logic             wfi_wait
);
    typedef struct packed {
        logic             rd_valid;
        logic [XLEN-1:0]  rd_data;
        logic             csr_we;
        logic [FN_W-1:0]  csr_waddr;
        logic [XLEN-1:0]  csr_wdata;
        logic             ret_take;
        logic [XLEN-1:0]  ret_pc;
        logic [1:0]       ret_priv;
        logic [XLEN-1:0]  status_wdata;
        logic             wfi_wait;
    } ctl_state_t;

    ctl_state_t st_d, st_q;

    logic            go;
    logic            priv_grp;
    logic            do_mret, do_sret, do_wfi;
    logic            rmw_is_csr, rmw_we;
    logic [XLEN-1:0] rmw_wdata;
    logic            ret_go;
    logic [XLEN-1:0] ret_pc_c, ret_status_c;
    logic [1:0]      ret_priv_c;
    logic            wake;

    // issue is blocked while the stall flag is up
    assign go       = issue_valid & ~st_q.wfi_wait;
    assign priv_grp = go && (funct3 == F3_PRIV);
    assign do_mret  = priv_grp && (funct12 == FN_MRET);
    assign do_sret  = priv_grp && (funct12 == FN_SRET);
    assign do_wfi   = priv_grp && (funct12 == FN_WFI);
    assign wake     = |(irq_enable & irq_pending);

    sys_csr_rmw #(.XLEN(XLEN)) u_rmw (
        .funct3  (funct3),
        .src_idx (src_idx),
        .src_val (src_val),
        .old_val (csr_old),
        .is_csr  (rmw_is_csr),
        .wr_en   (rmw_we),
        .wdata   (rmw_wdata)
    );

    sys_trap_ret #(.XLEN(XLEN)) u_ret (
        .do_mret    (do_mret),
        .do_sret    (do_sret),
        .mstatus    (mstatus_in),
        .mepc       (mepc_in),
        .sepc       (sepc_in),
        .take       (ret_go),
        .tgt_pc     (ret_pc_c),
        .tgt_priv   (ret_priv_c),
        .new_status (ret_status_c)
    );

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.csr_we   = 1'b0;
        st_d.ret_take = 1'b0;

        if (go && rmw_is_csr) begin
            st_d.rd_valid  = 1'b1;
            st_d.rd_data   = csr_old;
            st_d.csr_we    = rmw_we;
            st_d.csr_waddr = funct12;
            st_d.csr_wdata = rmw_wdata;
        end

        if (ret_go) begin
            st_d.ret_take     = 1'b1;
            st_d.ret_pc       = ret_pc_c;
            st_d.ret_priv     = ret_priv_c;
            st_d.status_wdata = ret_status_c;
        end

        if (st_q.wfi_wait) begin
            st_d.wfi_wait = ~wake;
        end else begin
            st_d.wfi_wait = do_wfi;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_valid     = st_q.rd_valid;
    assign rd_data      = st_q.rd_data;
    assign csr_we       = st_q.csr_we;
    assign csr_waddr    = st_q.csr_waddr;
    assign csr_wdata    = st_q.csr_wdata;
    assign ret_take     = st_q.ret_take;
    assign ret_pc       = st_q.ret_pc;
    assign ret_priv     = st_q.ret_priv;
    assign status_wdata = st_q.status_wdata;
    assign wfi_wait     = st_q.wfi_wait;
endmodule

// File: rtl/sys_ctl_unit_chk.sv
module sys_ctl_unit_chk #(
    parameter int XLEN = 64
) (
    input logic            clk,
    input logic            rst_n,
    input logic            issue_valid,
    input logic [XLEN-1:0] csr_old,
    input logic [XLEN-1:0] irq_enable,
    input logic [XLEN-1:0] irq_pending,
    input logic            rd_valid,
    input logic [XLEN-1:0] rd_data,
    input logic            csr_we,
    input logic            ret_take,
    input logic [1:0]      ret_priv,
    input logic [XLEN-1:0] status_wdata,
    input logic            wfi_wait
);
    // R11
    strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(csr_we && ret_take));

    // R11
    strobe_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (csr_we || ret_take || rd_valid) |-> $past(issue_valid));

    // R3
    old_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (rd_data == $past(csr_old)));

    // R7
    mprv_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_take && (ret_priv != 2'b11)) |-> !status_wdata[17]);

    // R8
    wake_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wfi_wait) |-> $past(|(irq_enable & irq_pending)));

    // R9
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wfi_wait) |-> (!csr_we && !ret_take && !rd_valid));
endmodule

bind sys_ctl_unit sys_ctl_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_valid  (issue_valid),
    .csr_old      (csr_old),
    .irq_enable   (irq_enable),
    .irq_pending  (irq_pending),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data),
    .csr_we       (csr_we),
    .ret_take     (ret_take),
    .ret_priv     (ret_priv),
    .status_wdata (status_wdata),
    .wfi_wait     (wfi_wait)
);

// File: tb/sim_sys_ctl_unit.sv
module sim_sys_ctl_unit;
    localparam int XLEN = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            issue_valid = 1'b0;
    logic [2:0]      funct3 = '0;
    logic [11:0]     funct12 = '0;
    logic [4:0]      src_idx = '0;
    logic [XLEN-1:0] src_val = '0;
    logic [XLEN-1:0] csr_old = '0;
    logic [XLEN-1:0] mstatus_in = '0;
    logic [XLEN-1:0] mepc_in = '0;
    logic [XLEN-1:0] sepc_in = '0;
    logic [XLEN-1:0] irq_enable = '0;
    logic [XLEN-1:0] irq_pending = '0;
    logic            rd_valid, csr_we, ret_take, wfi_wait;
    logic [XLEN-1:0] rd_data, csr_wdata, ret_pc, status_wdata;
    logic [11:0]     csr_waddr;
    logic [1:0]      ret_priv;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sys_ctl_unit #(.XLEN(XLEN)) u0 (
        .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid),
        .funct3(funct3), .funct12(funct12), .src_idx(src_idx),
        .src_val(src_val), .csr_old(csr_old), .mstatus_in(mstatus_in),
        .mepc_in(mepc_in), .sepc_in(sepc_in), .irq_enable(irq_enable),
        .irq_pending(irq_pending), .rd_valid(rd_valid), .rd_data(rd_data),
        .csr_we(csr_we), .csr_waddr(csr_waddr), .csr_wdata(csr_wdata),
        .ret_take(ret_take), .ret_pc(ret_pc), .ret_priv(ret_priv),
        .status_wdata(status_wdata), .wfi_wait(wfi_wait)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive one instruction on a falling edge; outputs are sampled on the next falling edge
    task automatic issue(input logic [2:0] f3, input logic [11:0] f12,
                         input logic [4:0] idx, input logic [63:0] val, input logic [63:0] old);
        @(negedge clk);
        funct3 = f3; funct12 = f12; src_idx = idx; src_val = val; csr_old = old;
        issue_valid = 1'b1;
        @(negedge clk);
        issue_valid = 1'b0;
    endtask

    task automatic t_reset();
        chk("R12 rd_valid", {63'd0, rd_valid}, 64'd0);
        chk("R12 csr_we", {63'd0, csr_we}, 64'd0);
        chk("R12 ret_take", {63'd0, ret_take}, 64'd0);
        chk("R12 wfi_wait", {63'd0, wfi_wait}, 64'd0);
    endtask

    task automatic t_reg_forms();
        issue(3'b001, 12'h340, 5'd5, 64'hDEAD_0000_0000_0001, 64'hF0F0);
        chk("R1 rw we", {63'd0, csr_we}, 64'd1);
        chk("R1 rw data", csr_wdata, 64'hDEAD_0000_0000_0001);
        chk("R1 rw addr", {52'd0, csr_waddr}, 64'h340);
        chk("R3 rw old", rd_data, 64'hF0F0);
        chk("R3 rw valid", {63'd0, rd_valid}, 64'd1);
        issue(3'b010, 12'h341, 5'd5, 64'h0FF3, 64'hF0F0);
        chk("R1 set data", csr_wdata, 64'hFFF3);
        chk("R3 set old", rd_data, 64'hF0F0);
        issue(3'b011, 12'h342, 5'd5, 64'h0FF3, 64'hF0F0);
        chk("R1 clear data", csr_wdata, 64'hF000);
        chk("R1 clear we", {63'd0, csr_we}, 64'd1);
    endtask

    task automatic t_imm_forms();
        issue(3'b101, 12'h100, 5'h13, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0);
        chk("R2 rwi data", csr_wdata, 64'h13);
        chk("R3 rwi old", rd_data, 64'hF0F0);
        issue(3'b110, 12'h100, 5'h13, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0);
        chk("R2 si data", csr_wdata, 64'hF0F3);
        issue(3'b111, 12'h100, 5'h13, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF0F0);
        chk("R2 ci data", csr_wdata, 64'hF0E0);
        issue(3'b110, 12'h100, 5'h1F, 64'd0, 64'd0);
        chk("R2 zero extend", csr_wdata, 64'h1F);
    endtask

    task automatic t_zero_operand();
        issue(3'b010, 12'h300, 5'd0, 64'h55, 64'h1234);
        chk("R4 set x0 no write", {63'd0, csr_we}, 64'd0);
        chk("R4 set x0 rd", rd_data, 64'h1234);
        chk("R4 set x0 rd valid", {63'd0, rd_valid}, 64'd1);
        issue(3'b111, 12'h300, 5'd0, 64'h55, 64'h1234);
        chk("R4 clear imm0 no write", {63'd0, csr_we}, 64'd0);
        issue(3'b001, 12'h300, 5'd0, 64'd0, 64'h1234);
        chk("R4 rw x0 writes", {63'd0, csr_we}, 64'd1);
        chk("R4 rw x0 data", csr_wdata, 64'd0);
        issue(3'b101, 12'h300, 5'd0, 64'h77, 64'h1234);
        chk("R4 rwi 0 writes", {63'd0, csr_we}, 64'd1);
        chk("R4 rwi 0 data", csr_wdata, 64'd0);
    endtask

    task automatic t_mret();
        mepc_in = 64'h8000_1000; sepc_in = 64'h9000_2000;
        mstatus_in = 64'h100_0002_1880;
        issue(3'b000, 12'h302, 5'd0, 64'd0, 64'd0);
        chk("R5 take", {63'd0, ret_take}, 64'd1);
        chk("R5 pc", ret_pc, 64'h8000_1000);
        chk("R5 priv", {62'd0, ret_priv}, 64'd3);
        chk("R7 keep mprv to M", status_wdata, 64'h100_0002_0088);
        chk("R11 no csr write on return", {63'd0, csr_we}, 64'd0);
        @(negedge clk);
        chk("R11 return strobe one cycle", {63'd0, ret_take}, 64'd0);
        mstatus_in = 64'h2_0808;
        issue(3'b000, 12'h302, 5'd0, 64'd0, 64'd0);
        chk("R5 priv S", {62'd0, ret_priv}, 64'd1);
        chk("R7 drop mprv", status_wdata, 64'h80);
    endtask

    task automatic t_sret();
        mstatus_in = 64'h2_1922;
        issue(3'b000, 12'h102, 5'd0, 64'd0, 64'd0);
        chk("R6 pc", ret_pc, 64'h9000_2000);
        chk("R6 priv", {62'd0, ret_priv}, 64'd1);
        chk("R6 status", status_wdata, 64'h1822);
        mstatus_in = 64'h2;
        issue(3'b000, 12'h102, 5'd0, 64'd0, 64'd0);
        chk("R6 priv U", {62'd0, ret_priv}, 64'd0);
        chk("R6 status U", status_wdata, 64'h20);
    endtask

    task automatic t_one_shot();
        issue(3'b001, 12'h140, 5'd3, 64'hAB, 64'hCD);
        chk("R11 we in result cycle", {63'd0, csr_we}, 64'd1);
        @(negedge clk);
        chk("R11 we dropped", {63'd0, csr_we}, 64'd0);
        chk("R11 rd_valid dropped", {63'd0, rd_valid}, 64'd0);
    endtask

    task automatic t_sfence();
        issue(3'b000, {7'b0001001, 5'd3}, 5'd4, 64'h1, 64'h2);
        chk("R10 no csr write", {63'd0, csr_we}, 64'd0);
        chk("R10 no rd", {63'd0, rd_valid}, 64'd0);
        chk("R10 no return", {63'd0, ret_take}, 64'd0);
        chk("R10 no wait", {63'd0, wfi_wait}, 64'd0);
    endtask

    task automatic t_wfi();
        irq_enable = 64'h80; irq_pending = 64'h20;
        issue(3'b000, 12'h105, 5'd0, 64'd0, 64'd0);
        chk("R8 wait set", {63'd0, wfi_wait}, 64'd1);
        repeat (3) @(negedge clk);
        chk("R8 wait held without match", {63'd0, wfi_wait}, 64'd1);
        issue(3'b001, 12'h340, 5'd2, 64'h9, 64'h1);
        chk("R9 ignored csr write", {63'd0, csr_we}, 64'd0);
        chk("R9 ignored rd", {63'd0, rd_valid}, 64'd0);
        mstatus_in = 64'h1880;
        issue(3'b000, 12'h302, 5'd0, 64'd0, 64'd0);
        chk("R9 ignored return", {63'd0, ret_take}, 64'd0);
        irq_pending = 64'hA0;
        @(negedge clk);
        chk("R8 wait released", {63'd0, wfi_wait}, 64'd0);
        irq_pending = 64'h0;
        issue(3'b010, 12'h340, 5'd2, 64'h9, 64'h1);
        chk("R9 issue resumes", {63'd0, csr_we}, 64'd1);
        chk("R9 resumed data", csr_wdata, 64'h9);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R11 actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reg_forms();
        t_imm_forms();
        t_zero_operand();
        t_one_shot();
        t_mret();
        t_sret();
        t_sfence();
        t_wfi();
        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule